// File: doc/BRIEF.md
# ADC Conversion Queue Sequencer

This block drives an external analog-to-digital converter through a programmed list of channel selections. Software fills a packed node list, sets how many nodes one pass covers, and fires a trigger. The sequencer then requests one conversion per node, in node order. It waits for each result and labels the result with the channel it came from. The labelled word goes into a result FIFO, which software drains through a data register.

When the final node of a pass has been converted, a done flag is raised in the status register. An interrupt line can mirror that flag. Both the done flag and the FIFO error flag are cleared by writing a one to them. The FIFO can be flushed, and it keeps sticky flags for a dropped push and for a read made while it is empty.

The register port is a simple word-addressed read/write strobe interface. Read data is registered and valid in the cycle after the read strobe. A read of the data word pops the FIFO.

Top module: `adcq_seq`

Register word addresses used below: 0 control, 1 node count, 2 node list, 3 status, 4 FIFO control, 5 FIFO data.

## Requirements
- R1: After reset every register reads zero, except FIFO control, which reads 0x800 (threshold field in bits [15:11] equals 1). `irq` and `adc_start` are low.
- R2: A control write with bit 0 (enable) and bit 22 (trigger) both set starts one pass. Exactly one `adc_start` pulse is issued per node. The channel is taken from bits [4k+3:4k] of the node list for node k, in ascending k. The next request is issued only after `adc_done`.
- R3: Each result is pushed as a data word {16'b0, channel[15:12], result[11:0]}. Words are read back in conversion order.
- R4: After the last result of a pass, status bit 0 reads 1. Writing 1 to status bit 0 clears it.
- R5: `irq` equals control bit 18 ANDed with status bit 0.
- R6: A trigger written while a pass is in progress, or while enable is 0, starts nothing. Control bit 22 always reads 0.
- R7: A node count of 0 sets status bit 0 without any `adc_start`. A count larger than the node capacity (8) is treated as 8.
- R8: A push into a full FIFO (16 words) is dropped. The oldest 16 words are kept, and FIFO control bit 16 is set and stays set.
- R9: Reading the data word while the FIFO is empty returns 0 and sets FIFO control bit 17.
- R10: Writing 1 to FIFO control bit 0 empties the FIFO and clears bits 16 and 17. Bit 0 reads 0, and the threshold field is kept.
- R11: Status bit 2 is set by an overflow or underflow only when FIFO control bit 3 is 1. Writing 1 to status bit 2 clears it.
- R12: Writing enable to 0 during a pass abandons it: no further requests and no done flag. The next trigger starts again from node 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| adc_start | output | 1 | One-cycle conversion request |
| adc_chan | output | 4 | Channel for the current request |
| adc_done | input | 1 | Converter result valid pulse |
| adc_data | input | 12 | Conversion result |
| irq | output | 1 | Queue-done interrupt |

## Verification
A table of passes is run through the sequencer. The passes use distinct node lists, a full list, a short list, a repeated-channel list and an oversized count. Each has a different converter latency, so node ordering, field extraction, count clamping and latency independence can each be told apart from the start log and the FIFO words. Directed runs cover the following:
- a zero-length pass;
- triggers while disabled and while busy;
- a mid-pass abort followed by a restart;
- three back-to-back passes that overfill the FIFO, which separates the kept words from the dropped ones;
- an empty read, and a flush with and without error reporting enabled.

// File: rtl/adcq_pkg.sv
package adcq_pkg;

  localparam int CHAN_W = 4;
  localparam int RES_W  = 12;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_COUNT = 3'd1;
  localparam logic [2:0] A_NODES = 3'd2;
  localparam logic [2:0] A_STAT  = 3'd3;
  localparam logic [2:0] A_FCTL  = 3'd4;
  localparam logic [2:0] A_FDATA = 3'd5;

  localparam int B_EN    = 0;
  localparam int B_IRQEN = 18;
  localparam int B_TRIG  = 22;
  localparam int B_DONE  = 0;
  localparam int B_FERR  = 2;
  localparam int B_FLUSH = 0;
  localparam int B_ERREN = 3;
  localparam int B_THR   = 11;
  localparam int B_OF    = 16;
  localparam int B_UF    = 17;

  typedef enum logic [0:0] {WK_IDLE, WK_WAIT} walk_state_t;

endpackage

// File: rtl/adcq_fifo.sv
module adcq_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty,
  output logic         ovf_evt,
  output logic         udf_evt
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;
  logic         do_push, do_pop;

  assign empty   = (wp == rp);
  assign full    = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign ovf_evt = push && full && !flush;
  assign udf_evt = pop && empty && !flush;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wp[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      rdata <= '0;
    end else begin
      if (flush) begin
        wp <= '0;
        rp <= '0;
      end else begin
        if (do_push) wp <= wp + 1'b1;
        if (do_pop)  rp <= rp + 1'b1;
      end
      if (pop) rdata <= do_pop ? mem[rp[AW-1:0]] : '0;
    end
  end

  assert_full_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && full && !flush) |=> full);
  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty);
  assert_empty_read_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !flush) |=> (rdata == '0));

endmodule

// File: rtl/adcq_walker.sv
module adcq_walker
  import adcq_pkg::*;
#(
  parameter int NODES = 8,
  parameter int CNT_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     enable,
  input  logic                     trig,
  input  logic [CNT_W-1:0]         count,
  input  logic [NODES*CHAN_W-1:0]  nodes,
  input  logic                     adc_done,
  input  logic [RES_W-1:0]         adc_data,
  output logic                     adc_start,
  output logic [CHAN_W-1:0]        adc_chan,
  output logic                     res_push,
  output logic [CHAN_W+RES_W-1:0]  res_word,
  output logic                     pass_done
);
  localparam logic [CNT_W-1:0] MAX_N = CNT_W'(NODES);

  walk_state_t        state;
  logic [CNT_W-1:0]   idx, len_q, eff_len, sel_idx;
  logic [CHAN_W-1:0]  node_ch [NODES];
  logic [CHAN_W-1:0]  sel_ch;
  logic               last;

  for (genvar g = 0; g < NODES; g++) begin : g_node
    assign node_ch[g] = nodes[g*CHAN_W +: CHAN_W];
  end

  assign eff_len = (count > MAX_N) ? MAX_N : count;
  assign sel_idx = (state == WK_WAIT) ? idx + 1'b1 : '0;
  assign last    = ((idx + 1'b1) == len_q);

  always_comb begin
    sel_ch = '0;
    for (int k = 0; k < NODES; k++) begin
      if (CNT_W'(k) == sel_idx) sel_ch = node_ch[k];
    end
  end

  assign res_push = (state == WK_WAIT) && adc_done && enable;
  assign res_word = {adc_chan, adc_data};

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= WK_IDLE;
      idx       <= '0;
      len_q     <= '0;
      adc_start <= 1'b0;
      adc_chan  <= '0;
      pass_done <= 1'b0;
    end else begin
      adc_start <= 1'b0;
      pass_done <= 1'b0;
      if (!enable) begin
        state <= WK_IDLE;
      end else begin
        case (state)
          WK_IDLE: if (trig) begin
            idx   <= '0;
            len_q <= eff_len;
            if (eff_len == '0) begin
              pass_done <= 1'b1;
            end else begin
              adc_start <= 1'b1;
              adc_chan  <= sel_ch;
              state     <= WK_WAIT;
            end
          end
          WK_WAIT: if (adc_done) begin
            if (last) begin
              state     <= WK_IDLE;
              pass_done <= 1'b1;
            end else begin
              idx       <= idx + 1'b1;
              adc_start <= 1'b1;
              adc_chan  <= sel_ch;
            end
          end
          default: state <= WK_IDLE;
        endcase
      end
    end
  end

  assert_chan_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (state == WK_WAIT && !adc_done && enable) |=> $stable(adc_chan));
  assert_zero_len_R7: assert property (@(posedge clk) disable iff (rst)
    (state == WK_IDLE && enable && trig && count == '0) |=> (pass_done && !adc_start));
  assert_busy_trig_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (state == WK_WAIT && enable && trig && !adc_done) |=> !adc_start);
  assert_abort_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!adc_start && !pass_done));

endmodule

// File: rtl/adcq_seq.sv
module adcq_seq
  import adcq_pkg::*;
#(
  parameter int NODES = 8,
  parameter int DEPTH = 16,
  parameter int CNT_W = 4,
  parameter int THR_W = 5,
  parameter int DW    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              adc_start,
  output logic [CHAN_W-1:0] adc_chan,
  input  logic              adc_done,
  input  logic [RES_W-1:0]  adc_data,
  output logic              irq
);
  localparam int WORD_W = CHAN_W + RES_W;
  localparam int LIST_W = NODES * CHAN_W;

  logic wr_ctrl, wr_cnt, wr_nodes, wr_stat, wr_fctl, pop, flush, trig, en_now;
  logic en_q, irqen_q, erren_q, of_q, uf_q, done_q, ferr_q, irq_q;
  logic irqen_n, done_n, ferr_n, of_n, uf_n;
  logic [CNT_W-1:0]  cnt_q;
  logic [LIST_W-1:0] nodes_q;
  logic [THR_W-1:0]  thr_q;
  logic [DW-1:0]     rd_q, rd_mux;
  logic              rd_fifo_q;
  logic              res_push, pass_done, ovf_evt, udf_evt, f_full, f_empty;
  logic [WORD_W-1:0] res_word, fifo_q;
  logic              unused_bits;

  assign unused_bits = ^{reg_wdata, f_full, f_empty};

  assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
  assign wr_cnt   = reg_wr && (reg_addr == A_COUNT);
  assign wr_nodes = reg_wr && (reg_addr == A_NODES);
  assign wr_stat  = reg_wr && (reg_addr == A_STAT);
  assign wr_fctl  = reg_wr && (reg_addr == A_FCTL);
  assign pop      = reg_rd && (reg_addr == A_FDATA);
  assign flush    = wr_fctl && reg_wdata[B_FLUSH];
  assign trig     = wr_ctrl && reg_wdata[B_TRIG];
  assign en_now   = wr_ctrl ? reg_wdata[B_EN] : en_q;

  adcq_walker #(.NODES(NODES), .CNT_W(CNT_W)) i_walker (
    .clk(clk), .rst(rst), .enable(en_now), .trig(trig),
    .count(cnt_q), .nodes(nodes_q),
    .adc_done(adc_done), .adc_data(adc_data),
    .adc_start(adc_start), .adc_chan(adc_chan),
    .res_push(res_push), .res_word(res_word), .pass_done(pass_done)
  );

  adcq_fifo #(.DEPTH(DEPTH), .W(WORD_W)) i_fifo (
    .clk(clk), .rst(rst), .flush(flush),
    .push(res_push), .wdata(res_word), .pop(pop),
    .rdata(fifo_q), .full(f_full), .empty(f_empty),
    .ovf_evt(ovf_evt), .udf_evt(udf_evt)
  );

  always_comb begin
    irqen_n = wr_ctrl ? reg_wdata[B_IRQEN] : irqen_q;
    done_n  = pass_done | (done_q & ~(wr_stat & reg_wdata[B_DONE]));
    ferr_n  = (erren_q & (ovf_evt | udf_evt)) | (ferr_q & ~(wr_stat & reg_wdata[B_FERR]));
    of_n    = flush ? 1'b0 : (of_q | ovf_evt);
    uf_n    = flush ? 1'b0 : (uf_q | udf_evt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      irqen_q <= 1'b0;
      cnt_q   <= '0;
      nodes_q <= '0;
      erren_q <= 1'b0;
      thr_q   <= THR_W'(1);
      of_q    <= 1'b0;
      uf_q    <= 1'b0;
      done_q  <= 1'b0;
      ferr_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q    <= reg_wdata[B_EN];
        irqen_q <= reg_wdata[B_IRQEN];
      end
      if (wr_cnt)   cnt_q   <= reg_wdata[CNT_W-1:0];
      if (wr_nodes) nodes_q <= reg_wdata[LIST_W-1:0];
      if (wr_fctl) begin
        erren_q <= reg_wdata[B_ERREN];
        thr_q   <= reg_wdata[B_THR +: THR_W];
      end
      of_q   <= of_n;
      uf_q   <= uf_n;
      done_q <= done_n;
      ferr_q <= ferr_n;
      irq_q  <= irqen_n && done_n;
    end
  end

  assign irq = irq_q;

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_CTRL: begin
        rd_mux[B_EN]    = en_q;
        rd_mux[B_IRQEN] = irqen_q;
      end
      A_COUNT: rd_mux[CNT_W-1:0]  = cnt_q;
      A_NODES: rd_mux[LIST_W-1:0] = nodes_q;
      A_STAT: begin
        rd_mux[B_DONE] = done_q;
        rd_mux[B_FERR] = ferr_q;
      end
      A_FCTL: begin
        rd_mux[B_ERREN]          = erren_q;
        rd_mux[B_THR +: THR_W]   = thr_q;
        rd_mux[B_OF]             = of_q;
        rd_mux[B_UF]             = uf_q;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q      <= '0;
      rd_fifo_q <= 1'b0;
    end else begin
      rd_fifo_q <= pop;
      if (reg_rd) rd_q <= rd_mux;
    end
  end

  assign reg_rdata = rd_fifo_q ? DW'(fifo_q) : rd_q;

  assert_irq_follows_R5: assert property (@(posedge clk) disable iff (rst)
    irq == (irqen_q && done_q));
  assert_done_w1c_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && reg_wdata[B_DONE] && !pass_done) |=> !done_q);
  assert_ferr_gated_R11: assert property (@(posedge clk) disable iff (rst)
    (!erren_q && !ferr_q) |=> !ferr_q);
  assert_sticky_of_R8: assert property (@(posedge clk) disable iff (rst)
    (of_q && !flush) |=> of_q);

endmodule

// File: tb/test_adcq_seq.sv
module test_adcq_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] AC = 3'd0, AN = 3'd1, AL = 3'd2, AS = 3'd3, AF = 3'd4, AD = 3'd5;
  localparam logic [31:0] EN = 32'h1, IE = 32'h1 << 18, TG = 32'h1 << 22;

  typedef struct packed {
    logic [31:0] nodes;
    logic [3:0]  cnt;
    logic [3:0]  lat;
    logic        irqen;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{32'h76543210, 4'd8,  4'd1, 1'b1},
    '{32'h00000A5F, 4'd3,  4'd4, 1'b0},
    '{32'hFEDCBA98, 4'd12, 4'd2, 1'b1},
    '{32'h11112223, 4'd5,  4'd3, 1'b0}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic adc_start, adc_done = 0, irq;
  logic [3:0] adc_chan;
  logic [11:0] adc_data = '0;

  int tests = 0, fails = 0;
  int lat = 1, pend = 0, n_starts = 0;
  logic [3:0] pend_ch;
  logic [3:0] log_ch [64];
  bit finished = 0;

  adcq_seq i_adcq_seq (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .adc_start(adc_start),
    .adc_chan(adc_chan), .adc_done(adc_done), .adc_data(adc_data), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [11:0] stub_val(logic [3:0] c);
    return 12'(int'(c) * 37 + 5);
  endfunction

  function automatic logic [31:0] word_of(logic [3:0] c);
    return {16'h0, c, stub_val(c)};
  endfunction

  // converter stub: answers each request after lat cycles, lat 0 never answers
  initial begin
    forever begin
      @(negedge clk);
      adc_done = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          adc_done = 1'b1;
          adc_data = stub_val(pend_ch);
        end
      end
      if (adc_start) begin
        if (n_starts < 64) log_ch[n_starts] = adc_chan;
        n_starts++;
        if (lat > 0) begin
          pend = lat;
          pend_ch = adc_chan;
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    @(posedge clk); #1;
    reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic wait_done(input string req);
    logic [31:0] v;
    bit ok = 0;
    for (int i = 0; i < 300 && !ok; i++) begin
      rd(AS, v);
      if (v[0]) ok = 1;
    end
    chk(req, "pass done seen", 32'(ok), 32'd1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int exp_n;
    repeat (3) @(posedge clk);
    #1 rst = 0;

    // R1 reset state
    chk("R1", "irq", 32'(irq), 0);
    chk("R1", "adc_start", 32'(adc_start), 0);
    rd(AC, v); chk("R1", "ctrl", v, 0);
    rd(AN, v); chk("R1", "count", v, 0);
    rd(AL, v); chk("R1", "nodes", v, 0);
    rd(AS, v); chk("R1", "status", v, 0);
    rd(AF, v); chk("R1", "fifo ctrl", v, 32'h800);

    // table of passes: R2 R3 R4 R5 R7
    for (int t = 0; t < 4; t++) begin
      lat = int'(VECS[t].lat);
      wr(AN, 32'(VECS[t].cnt));
      wr(AL, VECS[t].nodes);
      n_starts = 0;
      wr(AC, EN | TG | (VECS[t].irqen ? IE : 32'h0));
      wait_done("R4");
      exp_n = (VECS[t].cnt > 8) ? 8 : int'(VECS[t].cnt);
      chk("R7", "request count (clamped)", 32'(n_starts), 32'(exp_n));
      for (int k = 0; k < exp_n; k++)
        chk("R2", "node channel order", 32'(log_ch[k]), 32'(VECS[t].nodes[4*k +: 4]));
      chk("R5", "irq with done", 32'(irq), 32'(VECS[t].irqen));
      for (int k = 0; k < exp_n; k++) begin
        rd(AD, v);
        chk("R3", "result word", v, word_of(VECS[t].nodes[4*k +: 4]));
      end
      wr(AS, 32'h1);
      rd(AS, v); chk("R4", "done cleared", 32'(v[0]), 0);
      chk("R5", "irq after clear", 32'(irq), 0);
    end

    // R7 zero-length pass
    wr(AN, 0);
    n_starts = 0;
    wr(AC, EN | TG);
    idle(3);
    rd(AS, v); chk("R7", "zero count done", 32'(v[0]), 1);
    chk("R7", "zero count no request", 32'(n_starts), 0);
    wr(AS, 32'h1);

    // R6 trigger with enable off
    wr(AN, 3);
    wr(AL, 32'h00000321);
    wr(AC, 0);
    n_starts = 0;
    wr(AC, TG);
    idle(10);
    chk("R6", "disabled trigger no request", 32'(n_starts), 0);
    rd(AS, v); chk("R6", "disabled trigger no done", v, 0);
    rd(AC, v); chk("R6", "trigger bit reads 0", v, 0);

    // R6 busy trigger, R12 abort and restart
    lat = 0;
    wr(AC, EN | TG);
    idle(5);
    chk("R6", "first request", 32'(n_starts), 1);
    wr(AC, EN | TG);
    idle(5);
    chk("R6", "busy trigger ignored", 32'(n_starts), 1);
    rd(AC, v); chk("R6", "ctrl readback", v, EN);
    wr(AC, 0);
    lat = 1;
    idle(10);
    chk("R12", "no request after abort", 32'(n_starts), 1);
    rd(AS, v); chk("R12", "no done after abort", 32'(v[0]), 0);
    wr(AC, EN | TG);
    wait_done("R12");
    chk("R12", "restart request count", 32'(n_starts), 4);
    chk("R12", "restart from node 0", 32'(log_ch[1]), 32'h1);
    for (int k = 0; k < 3; k++) begin
      rd(AD, v); chk("R12", "restart word", v, word_of(4'(k + 1)));
    end
    wr(AS, 32'h1);

    // R8 R11 overflow with error report on
    wr(AF, 32'h808);
    wr(AN, 8);
    wr(AL, 32'h76543210);
    for (int p = 0; p < 3; p++) begin
      wr(AC, EN | TG);
      wait_done("R8");
      wr(AS, 32'h1);
    end
    rd(AF, v); chk("R8", "overflow flag", v, 32'h1_0808);
    rd(AS, v); chk("R11", "error flag on overflow", 32'(v[2]), 1);
    for (int k = 0; k < 16; k++) begin
      rd(AD, v); chk("R8", "kept word", v, word_of(4'(k % 8)));
    end
    rd(AD, v); chk("R9", "empty read zero", v, 0);
    rd(AF, v); chk("R9", "underflow flag", 32'(v[17]), 1);
    wr(AS, 32'h4);
    rd(AS, v); chk("R11", "error flag cleared", 32'(v[2]), 0);

    // R10 flush, R11 with reporting off
    wr(AF, 32'h800);
    wr(AN, 2);
    wr(AC, EN | TG);
    wait_done("R10");
    wr(AS, 32'h1);
    wr(AF, 32'h801);
    rd(AF, v); chk("R10", "flags cleared, threshold kept", v, 32'h800);
    rd(AD, v); chk("R10", "flushed fifo empty", v, 0);
    rd(AF, v); chk("R9", "underflow after flush", v, 32'h2_0800);
    rd(AS, v); chk("R11", "no error when disabled", 32'(v[2]), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule